// File: doc/BRIEF.md
# Asynchronous External Memory Controller

This block turns internal read and write requests into bus cycles on an asynchronous external memory with a single chip-select. Each external access has three phases: address setup, an active strobe, and hold. Each phase has its own programmable length, and reads and writes are timed separately. All timing comes from one packed 32-bit configuration word. After each request completes, the controller leaves a programmable turnaround gap before it starts the next one.

The external data pins are 16 bits wide. The bus can run as a 16-bit bus or as an 8-bit bus on the low byte lane. A request is 16 or 32 bits wide. When a request is wider than the bus, the controller splits it into back-to-back bus cycles:
- The least significant lane goes first, at the request address.
- Each later lane goes to the next external address.

The whole sequencer advances on an interface clock enable. This enable runs at the system clock rate or at half of it.

A requester holds `req_valid` and its request fields stable until `req_ready` pulses. The controller latches the request and the configuration word when it accepts the request. It acknowledges only after the hold phase of the last split cycle. Read data is valid on `rsp_rdata` in the acknowledge cycle.

Top module: `amem_ctrl`

## Requirements
- R1: The configuration word is decoded by bit position:
  - bit 31: chip-select-on-strobe mode
  - bit 30: wait-extension flag
  - bits 29:26: write setup
  - bits 25:20: write strobe
  - bits 19:17: write hold
  - bits 16:13: read setup
  - bits 12:7: read strobe
  - bits 6:4: read hold
  - bits 3:2: turnaround
  - bits 1:0: bus size

  Each phase lasts its field value plus one interface clocks. With chip-select-on-strobe mode off, `ext_cs_n` is low for (setup+strobe+hold+3) interface clocks per bus cycle.
- R2: During the strobe phase, `ext_we_n` is low for writes and `ext_re_n` is low for reads. The other strobe stays high, and the two strobes are never low together.
- R3: Bus size 00 selects an 8-bit bus on `ext_dout[7:0]` with the upper byte driven to zero. Any other code, including 01, selects a 16-bit bus.
  - The number of bus cycles is the request width divided by the bus width (`req_wide`=1 means 32 bits).
  - Cycle k uses `ext_addr` = `req_addr`+k and carries request bits [k*w+w-1 : k*w], where w is the bus width.
  - `ext_addr` and `ext_dout` are stable while a strobe is low.
- R4: In a read, the lane for cycle k is sampled from `ext_din` at the clock edge that ends its strobe. It is placed in `rsp_rdata` bits [k*w+w-1 : k*w], and the bits above the request width are zero.
- R5: With `half_rate`=1, every phase length in system clocks is doubled.
- R6: Back-to-back requests with chip-select-on-strobe mode off see `ext_cs_n` high for exactly (turnaround+2) interface clocks between them, with no strobe active. This is turnaround+1 clocks of gap plus one clock to accept the next request.
- R7: With chip-select-on-strobe mode on, `ext_cs_n` is low only while a strobe is low.
- R8: `req_ready` is high for exactly one system clock per request. It is high in the system clock right after the last hold clock of the final split cycle.
- R9: During and right after reset, `ext_cs_n`, `ext_we_n` and `ext_re_n` are high, and `ext_oe` and `req_ready` are low.
- R10: The wait-extension flag (bit 30) has no effect on bus timing or on data.
- R11: `ext_oe` is high while a write strobe is low and low while a read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_rate | input | 1 | 1: interface clock is system clock divided by two |
| cfg_word | input | 32 | Packed timing and bus-size configuration |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1: write, 0: read |
| req_wide | input | 1 | 1: 32-bit request, 0: 16-bit request |
| req_addr | input | ADDR_W | External address of the lowest lane |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | One-cycle completion acknowledge |
| rsp_rdata | output | 32 | Assembled read data |
| ext_addr | output | ADDR_W | External address |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |
| ext_oe | output | 1 | Data pin drive enable |
| ext_cs_n | output | 1 | Chip-select, active low |
| ext_we_n | output | 1 | Write strobe, active low |
| ext_re_n | output | 1 | Read strobe, active low |

## Verification
A phase counter that loads the wrong field, or miscounts by one, shows up in the same bus cycle. The strobe width or the chip-select width then differs from the expected product of field+1 and the clock divisor. A wrong beat index shows up at the next strobe as an address or data lane that does not match. It also shows up at acknowledge as a wrong number of strobes or misplaced read halves. A sequencer that skips the turnaround state or fails to return to idle shows up in the chip-select gap before the following request, or as a missing `req_ready`.

// File: rtl/amem_pkg.sv
`timescale 1ns/1ps
package amem_pkg;
  localparam int REQ_W     = 32;
  localparam int EXT_W     = 16;
  localparam int CNT_W     = 6;
  localparam int MAX_BEATS = REQ_W / 8;
  localparam int BEAT_W    = $clog2(MAX_BEATS);
  localparam int OFF_W     = $clog2(REQ_W);
  localparam logic [1:0] BSZ_BYTE = 2'b00;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_TURN
  } phase_t;

  // field order is fixed by bit position in the configuration word
  typedef struct packed {
    logic       cs_on_strobe;
    logic       wait_ext;
    logic [3:0] wr_setup;
    logic [5:0] wr_strobe;
    logic [2:0] wr_hold;
    logic [3:0] rd_setup;
    logic [5:0] rd_strobe;
    logic [2:0] rd_hold;
    logic [1:0] turn;
    logic [1:0] bus_size;
  } cfg_t;

  function automatic logic byte_bus(input logic [1:0] bsz);
    return bsz == BSZ_BYTE;
  endfunction

  // index of the final split cycle
  function automatic logic [BEAT_W-1:0] last_beat(input logic [1:0] bsz, input logic wide);
    if (byte_bus(bsz)) return wide ? BEAT_W'(3) : BEAT_W'(1);
    return wide ? BEAT_W'(1) : BEAT_W'(0);
  endfunction

  // counter preload: phase lasts value+1 interface clocks
  function automatic logic [CNT_W-1:0] phase_field(input cfg_t c, input phase_t p, input logic wr);
    case (p)
      PH_SETUP:  return wr ? CNT_W'(c.wr_setup)  : CNT_W'(c.rd_setup);
      PH_STROBE: return wr ? CNT_W'(c.wr_strobe) : CNT_W'(c.rd_strobe);
      PH_HOLD:   return wr ? CNT_W'(c.wr_hold)   : CNT_W'(c.rd_hold);
      PH_TURN:   return CNT_W'(c.turn);
      default:   return '0;
    endcase
  endfunction

  // bit offset of the lane moved in a given split cycle
  function automatic logic [OFF_W-1:0] lane_shift(input logic [1:0] bsz, input logic [BEAT_W-1:0] beat);
    if (byte_bus(bsz)) return OFF_W'({beat, 3'b000});
    return OFF_W'({beat[0], 4'b0000});
  endfunction
endpackage

// File: rtl/amem_tick.sv
`timescale 1ns/1ps
module amem_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic half_rate,
  output logic tick
);
  logic alt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alt_q <= 1'b0;
    else        alt_q <= ~alt_q;
  end

  assign tick = ~half_rate | alt_q;

  p_tick_alternate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (half_rate && tick) |=> (!tick || !half_rate));
endmodule

// File: rtl/amem_seq.sv
`timescale 1ns/1ps
module amem_seq import amem_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  cfg_t              cfg_in,
  output logic              accept,
  output logic              capture,
  output logic [BEAT_W-1:0] beat,
  output logic [1:0]        bus_size,
  output logic              ack,
  output logic              cs_n,
  output logic              we_n,
  output logic              re_n,
  output logic              oe
);
  phase_t            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  cfg_t              cfg_q;
  logic              wr_q, wide_q, ack_q;

  logic phase_done, final_beat, in_beat, in_strobe, ack_d;
  logic ext_flag_unused;

  assign phase_done = tick && (cnt_q == '0);
  assign final_beat = (beat_q == last_beat(cfg_q.bus_size, wide_q));
  assign in_beat    = ph_q inside {PH_SETUP, PH_STROBE, PH_HOLD};
  assign in_strobe  = (ph_q == PH_STROBE);
  assign accept     = tick && (ph_q == PH_IDLE) && req_valid;
  assign capture    = phase_done && in_strobe && !wr_q;
  assign ack_d      = phase_done && (ph_q == PH_HOLD) && final_beat;
  assign ext_flag_unused = cfg_q.wait_ext;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    beat_d = beat_q;
    if (accept) begin
      ph_d   = PH_SETUP;
      cnt_d  = phase_field(cfg_in, PH_SETUP, req_write);
      beat_d = '0;
    end else if (tick && ph_q != PH_IDLE) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end else begin
        case (ph_q)
          PH_SETUP: begin
            ph_d  = PH_STROBE;
            cnt_d = phase_field(cfg_q, PH_STROBE, wr_q);
          end
          PH_STROBE: begin
            ph_d  = PH_HOLD;
            cnt_d = phase_field(cfg_q, PH_HOLD, wr_q);
          end
          PH_HOLD: begin
            if (final_beat) begin
              ph_d  = PH_TURN;
              cnt_d = phase_field(cfg_q, PH_TURN, wr_q);
            end else begin
              ph_d   = PH_SETUP;
              cnt_d  = phase_field(cfg_q, PH_SETUP, wr_q);
              beat_d = beat_q + 1'b1;
            end
          end
          default: ph_d = PH_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      beat_q <= '0;
      cfg_q  <= '0;
      wr_q   <= 1'b0;
      wide_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      beat_q <= beat_d;
      ack_q  <= ack_d;
      if (accept) begin
        cfg_q  <= cfg_in;
        wr_q   <= req_write;
        wide_q <= req_wide;
      end
    end
  end

  assign beat     = beat_q;
  assign bus_size = cfg_q.bus_size;
  assign ack      = ack_q;
  assign cs_n     = !(in_beat && (!cfg_q.cs_on_strobe || in_strobe));
  assign we_n     = !(in_strobe && wr_q);
  assign re_n     = !(in_strobe && !wr_q);
  assign oe       = in_beat && wr_q;

  p_strobe_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  p_ready_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
  p_ready_after_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> ($past(ph_q) == PH_HOLD));
  p_turn_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_TURN) |-> (cs_n && we_n && re_n));
  p_strobe_under_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> !cs_n);
  p_read_no_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !oe);
endmodule

// File: rtl/amem_lane.sv
`timescale 1ns/1ps
module amem_lane import amem_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REQ_W-1:0]  req_wdata,
  input  logic [1:0]        bus_size,
  input  logic [BEAT_W-1:0] beat,
  input  logic [EXT_W-1:0]  ext_din,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [EXT_W-1:0]  ext_dout,
  output logic [REQ_W-1:0]  rdata
);
  logic [ADDR_W-1:0] addr_q;
  logic [REQ_W-1:0]  wdata_q, rdata_q;
  logic [OFF_W-1:0]  shift;
  logic [EXT_W-1:0]  lane_mask;
  logic              narrow;

  assign narrow    = byte_bus(bus_size);
  assign shift     = lane_shift(bus_size, beat);
  assign lane_mask = narrow ? EXT_W'(16'h00FF) : {EXT_W{1'b1}};
  assign ext_dout  = EXT_W'(wdata_q >> shift) & lane_mask;
  assign ext_addr  = addr_q + ADDR_W'(beat);
  assign rdata     = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= (rdata_q & ~(REQ_W'(lane_mask) << shift))
               | (REQ_W'(ext_din & lane_mask) << shift);
    end
  end

  p_capture_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !accept) |=> $stable(rdata_q));
endmodule

// File: rtl/amem_ctrl.sv
`timescale 1ns/1ps
module amem_ctrl import amem_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_rate,
  input  logic [31:0]       cfg_word,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REQ_W-1:0]  req_wdata,
  output logic              req_ready,
  output logic [REQ_W-1:0]  rsp_rdata,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [EXT_W-1:0]  ext_dout,
  input  logic [EXT_W-1:0]  ext_din,
  output logic              ext_oe,
  output logic              ext_cs_n,
  output logic              ext_we_n,
  output logic              ext_re_n
);
  cfg_t              cfg_in;
  logic              tick, accept, capture;
  logic [BEAT_W-1:0] beat;
  logic [1:0]        bus_size;

  assign cfg_in = cfg_t'(cfg_word);

  amem_tick u_tick (
    .clk(clk), .rst_n(rst_n), .half_rate(half_rate), .tick(tick)
  );

  amem_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
    .cfg_in(cfg_in), .accept(accept), .capture(capture),
    .beat(beat), .bus_size(bus_size), .ack(req_ready),
    .cs_n(ext_cs_n), .we_n(ext_we_n), .re_n(ext_re_n), .oe(ext_oe)
  );

  amem_lane #(.ADDR_W(ADDR_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_size(bus_size), .beat(beat), .ext_din(ext_din),
    .ext_addr(ext_addr), .ext_dout(ext_dout), .rdata(rsp_rdata)
  );

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_we_n && $past(!ext_we_n)) |-> ($stable(ext_addr) && $stable(ext_dout)));
endmodule

// File: tb/amem_ctrl_test.sv
`timescale 1ns/1ps
module amem_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        half_rate = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready;
  logic [31:0] rsp_rdata;
  logic [7:0]  ext_addr;
  logic [15:0] ext_dout, ext_din;
  logic        ext_oe, ext_cs_n, ext_we_n, ext_re_n;

  always #2.5 clk = ~clk;

  amem_ctrl #(.ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .half_rate(half_rate), .cfg_word(cfg_word),
    .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_rdata(rsp_rdata), .ext_addr(ext_addr), .ext_dout(ext_dout),
    .ext_din(ext_din), .ext_oe(ext_oe), .ext_cs_n(ext_cs_n),
    .ext_we_n(ext_we_n), .ext_re_n(ext_re_n)
  );

  // external device: reads return an address pattern only while the read strobe is low
  function automatic logic [15:0] pat(input logic [7:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction
  assign ext_din = !ext_re_n ? pat(ext_addr) : 16'hC3C3;

  logic [15:0] wmem [0:255];
  always @(posedge clk) if (!ext_we_n) wmem[ext_addr] <= ext_dout;

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] lane_of(input logic [31:0] d, input bit narrow, input int k);
    if (narrow) return 16'(d >> (8 * k)) & 16'h00FF;
    return 16'(d >> (16 * k));
  endfunction

  int r_cs, r_we, r_re, r_falls, r_lead, r_last_cs, r_ready_n;
  bit r_addr_bad, r_data_bad, r_oe_bad, r_gap_bad, r_done;
  logic [31:0] r_rdata;

  task automatic run_req(input bit wr, input bit wide, input logic [7:0] addr,
                         input logic [31:0] wdata, input logic [31:0] cfg,
                         input bit half, input bit chain, input bit no_wait);
    int n, k;
    bit stb, prev_stb, seen_cs, narrow;
    if (!no_wait) @(negedge clk);
    half_rate = half; cfg_word = cfg; req_write = wr; req_wide = wide;
    req_addr = addr; req_wdata = wdata; req_valid = 1'b1;
    narrow = (cfg[1:0] == 2'b00);
    r_cs = 0; r_we = 0; r_re = 0; r_falls = 0; r_lead = 0; r_last_cs = -1; r_ready_n = -1;
    r_addr_bad = 0; r_data_bad = 0; r_oe_bad = 0; r_gap_bad = 0; r_done = 0; r_rdata = '0;
    n = 0; k = 0; prev_stb = 0; seen_cs = 0;
    while (!r_done && n < 4000) begin
      @(negedge clk);
      n++;
      stb = !ext_we_n || !ext_re_n;
      if (!ext_cs_n) begin r_cs++; r_last_cs = n; seen_cs = 1; end
      else if (!seen_cs) begin r_lead++; if (stb) r_gap_bad = 1; end
      if (!ext_we_n) r_we++;
      if (!ext_re_n) r_re++;
      if (stb && !prev_stb) r_falls++;
      if (stb) begin
        k = r_falls - 1;
        if (ext_addr !== 8'(addr + 8'(k))) r_addr_bad = 1;
      end
      if (!ext_we_n && ext_dout !== lane_of(wdata, narrow, k)) r_data_bad = 1;
      if (!ext_we_n && !ext_oe) r_oe_bad = 1;
      if (!ext_re_n && ext_oe) r_oe_bad = 1;
      prev_stb = stb;
      if (req_ready) begin
        r_done = 1; r_ready_n = n; r_rdata = rsp_rdata;
        if (!chain) req_valid = 1'b0;
      end
    end
    if (!r_done) begin
      check(0, "R8 request never acknowledged", 0, 1);
      req_valid = 1'b0;
    end else if (!chain) begin
      @(negedge clk);
      check(req_ready == 1'b0, "R8 ready lasts one clock", int'(req_ready), 0);
    end
  endtask

  initial begin
    #750000;
    check(0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] cfg, rd0;
    int cs0;
    repeat (4) @(negedge clk);
    // R9: outputs idle during reset
    check(ext_cs_n && ext_we_n && ext_re_n && !ext_oe && !req_ready,
          "R9 idle outputs in reset", {ext_cs_n, ext_we_n, ext_re_n, ext_oe, req_ready}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    check(ext_cs_n && ext_we_n && ext_re_n && !ext_oe && !req_ready,
          "R9 idle outputs after reset", {ext_cs_n, ext_we_n, ext_re_n, ext_oe, req_ready}, 5'b11100);

    // sweep: bus size x width x direction x rate x chip-select mode
    for (int i = 0; i < 64; i++) begin
      bit [1:0] bsz;
      bit wide, wr, half, ss, ew, narrow;
      int su, st, hd, d, nb, exp_stb, exp_cs, exp_rdy, ws, wst, wh, rs, rst, rh, ta;
      logic [7:0] addr;
      logic [31:0] wdata, exp_rd;
      bit mem_ok;
      bsz = 2'(i); wide = i[2]; wr = i[3]; half = i[4]; ss = i[5]; ew = i[0] ^ i[3];
      ws = i % 5; wst = (i * 3) % 7; wh = i % 4;
      rs = (i + 2) % 4; rst = (i * 5) % 6; rh = (i + 1) % 3; ta = (i / 3) % 4;
      cfg = {ss, ew, 4'(ws), 6'(wst), 3'(wh), 4'(rs), 6'(rst), 3'(rh), 2'(ta), bsz};
      addr = 8'((i * 12) & 8'hFC);
      wdata = (32'h1000_0001 * i) ^ 32'hA5C3_3C5A;
      d = half ? 2 : 1;
      narrow = (bsz == 2'b00);
      nb = narrow ? (wide ? 4 : 2) : (wide ? 2 : 1);
      su = wr ? ws : rs; st = wr ? wst : rst; hd = wr ? wh : rh;
      exp_stb = nb * (st + 1) * d;
      exp_cs = ss ? exp_stb : nb * (su + st + hd + 3) * d;
      run_req(wr, wide, addr, wdata, cfg, half, 0, 0);
      check(r_falls == nb, "R3 split cycle count", r_falls, nb);
      check(r_we == (wr ? exp_stb : 0), "R2 write strobe clocks", r_we, wr ? exp_stb : 0);
      check(r_re == (wr ? 0 : exp_stb), "R2 read strobe clocks", r_re, wr ? 0 : exp_stb);
      if (ss)        check(r_cs == exp_cs, "R7 chip-select only in strobe", r_cs, exp_cs);
      else if (half) check(r_cs == exp_cs, "R5 half-rate cycle length", r_cs, exp_cs);
      else           check(r_cs == exp_cs, "R1 phase lengths", r_cs, exp_cs);
      check(!r_addr_bad, "R3 split address order", int'(r_addr_bad), 0);
      check(!r_oe_bad, "R11 drive enable", int'(r_oe_bad), 0);
      exp_rdy = ss ? r_last_cs + (hd + 1) * d + 1 : r_last_cs + 1;
      check(r_ready_n == exp_rdy, "R8 ready after final hold", r_ready_n, exp_rdy);
      if (wr) begin
        check(!r_data_bad, "R3 write lane data", int'(r_data_bad), 0);
        mem_ok = 1;
        for (int k = 0; k < nb; k++)
          if (wmem[8'(addr + 8'(k))] !== lane_of(wdata, narrow, k)) mem_ok = 0;
        check(mem_ok, "R3 stored lanes", int'(mem_ok), 1);
      end else begin
        exp_rd = '0;
        for (int k = 0; k < nb; k++)
          exp_rd = exp_rd | (narrow ? (32'(pat(8'(addr + 8'(k))) & 16'h00FF) << (8 * k))
                                    : (32'(pat(8'(addr + 8'(k)))) << (16 * k)));
        check(r_rdata == exp_rd, "R4 assembled read data", int'(r_rdata), int'(exp_rd));
      end
    end

    // R10: wait-extension flag changes nothing
    cfg = {1'b0, 1'b0, 4'd2, 6'd3, 3'd1, 4'd1, 6'd2, 3'd2, 2'd1, 2'b01};
    run_req(0, 1, 8'h40, '0, cfg, 0, 0, 0);
    cs0 = r_cs; rd0 = r_rdata;
    run_req(0, 1, 8'h40, '0, cfg | 32'h4000_0000, 0, 0, 0);
    check(r_cs == cs0, "R10 flag leaves timing", r_cs, cs0);
    check(r_rdata == rd0, "R10 flag leaves data", int'(r_rdata), int'(rd0));

    // R6: turnaround gap between chained requests
    for (int h = 0; h < 2; h++) begin
      for (int ta = 0; ta < 4; ta++) begin
        int d, exp_gap;
        d = (h != 0) ? 2 : 1;
        cfg = {1'b0, 1'b0, 4'd1, 6'd2, 3'd1, 4'd0, 6'd1, 3'd0, 2'(ta), 2'b01};
        run_req(1, 0, 8'h80, 32'h0000_1234, cfg, h != 0, 1, 0);
        run_req(1, 0, 8'h82, 32'h0000_5678, cfg, h != 0, 0, 1);
        exp_gap = (ta + 2) * d - 1;
        check(r_lead == exp_gap, "R6 chip-select gap", r_lead, exp_gap);
        check(!r_gap_bad, "R6 no strobe in gap", int'(r_gap_bad), 0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule